// File: doc/BRIEF.md
# Bus-Hold DMA Transfer Controller

This block is a single-channel DMA engine on a shared system bus. Software programs a start address, a byte count, a transfer direction and a peripheral identifier, then arms the channel. When the peripheral raises its request line, the engine requests the bus from the processor through a hold request / hold acknowledge handshake. It then keeps the bus for the whole block, with one bus cycle per byte.

Once the processor grants the bus, the engine acknowledges the peripheral and drives the peripheral identifier. Each byte then takes a fixed three-clock cycle: address setup, strobe active, strobe release. During the strobe clock a memory strobe and an I/O strobe are both active. A memory read pairs with an I/O write, or an I/O read pairs with a memory write, depending on direction. The address pointer rises by one and the remaining count falls by one after every byte.

When the count reaches zero, the engine drops hold request and device acknowledge together, disarms itself and sets a sticky completion interrupt. Software clears that interrupt by writing a one to it.

Top module: `dma_hold_engine`

## Requirements
- R1: After reset, hold_req, dev_ack, bus_addr, dev_sel, all four strobes and irq are 0, and the channel is disarmed.
- R2: The engine stays idle while the channel is disarmed, whatever dev_req does. An armed channel starts on the first clock edge at which dev_req is high.
- R3: hold_req rises one clock after the start. It stays high without a break until the clock after the last byte's release clock.
- R4: The engine drives no bus signal and no dev_ack until it samples bus_grant high. dev_ack rises one clock after that sample, and dev_sel shows the programmed identifier while dev_ack is high. dev_ack falls in the same clock as hold_req.
- R5: Each byte takes three clocks after the one-clock acknowledge phase. In the first clock the address is driven with no strobe. In the second the strobes are active. In the third the strobes are off and the address is still held.
- R6: With ctrl bit 1 at 0, the strobes are mem_rd together with io_wr. With ctrl bit 1 at 1, they are io_rd together with mem_wr. The other pair stays low.
- R7: The first byte uses the programmed start address. Each following byte uses the previous address plus one, and exactly as many bytes are moved as were programmed.
- R8: A programmed count of zero moves exactly one byte.
- R9: On completion, irq is set and the channel is disarmed. irq stays set until a write to select 3 with data bit 0 at 1. A write there with bit 0 at 0 leaves irq set.
- R10: Writes to select 0, 1 and 2 are ignored while a transfer is in progress.
- R11: Register selects: 0 is control, with bit 0 arm, bit 1 direction and bits 2 and up the device identifier. 1 is the start address, 2 is the byte count and 3 is the interrupt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | REG_W | Register write data |
| irq | output | 1 | Sticky completion interrupt |
| dev_req | input | 1 | Peripheral service request |
| dev_ack | output | 1 | Peripheral acknowledge |
| dev_sel | output | DEV_W | Peripheral identifier, valid with dev_ack |
| hold_req | output | 1 | Bus hold request to the processor |
| bus_grant | input | 1 | Hold acknowledge from the processor |
| bus_addr | output | ADDR_W | Memory address, zero when not driving |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
A behavioural model follows every clock and compares all outputs. The stimulus first holds the request high while the channel is disarmed, which shows whether arming gates the start. It then runs a four-byte transfer in each direction, which separates the two strobe pairings and checks address stepping. The grant delays differ between transfers, which checks that nothing moves before the grant.

During one transfer the bench rewrites the address, count and control registers. It then re-arms without reprogramming, so a write that leaked through would show up as wrong addresses or a wrong length. One-byte and zero-count transfers mark the end-of-count boundary, and the two interrupt-clear writes check that the interrupt is sticky.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ACK,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE
    } dma_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 3,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              busy,
    input  logic              done,
    output logic              arm,
    output logic              dir,
    output logic [DEV_W-1:0]  dev,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W-1:0]  count,
    output logic              irq
);
    typedef struct packed {
        logic              arm;
        logic              dir;
        logic [DEV_W-1:0]  dev;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              irq;
    } cfg_t;

    cfg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we && !busy) begin
            case (cfg_sel)
                SEL_CTRL: begin
                    r_d.arm = cfg_wdata[0];
                    r_d.dir = cfg_wdata[1];
                    r_d.dev = cfg_wdata[2 +: DEV_W];
                end
                SEL_ADDR: r_d.addr = cfg_wdata[ADDR_W-1:0];
                SEL_CNT:  r_d.cnt  = cfg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        if (cfg_we && cfg_sel == SEL_STAT && cfg_wdata[0])
            r_d.irq = 1'b0;
        if (done) begin
            r_d.arm = 1'b0;
            r_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign arm        = r_q.arm;
    assign dir        = r_q.dir;
    assign dev        = r_q.dev;
    assign start_addr = r_q.addr;
    assign count      = r_q.cnt;
    assign irq        = r_q.irq;

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(r_q.addr) && $stable(r_q.cnt) && $stable(r_q.dir) && $stable(r_q.dev)));

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.irq && !(cfg_we && cfg_sel == SEL_STAT && cfg_wdata[0])) |=> r_q.irq);
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic              busy,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
    } dp_t;

    dp_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.addr = load_addr;
            r_d.left = (load_cnt == '0) ? ONE : load_cnt;
        end else if (step) begin
            r_d.addr = r_q.addr + ADDR_W'(1);
            r_d.left = r_q.left - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cur_addr = r_q.addr;
    assign last     = (r_q.left == ONE);

    p_left_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.left != '0));

    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic dreq,
    input  logic hlda,
    input  logic last,
    output logic start,
    output logic step,
    output logic done,
    output logic busy,
    output logic hrq,
    output logic dack,
    output logic drive,
    output logic strobe
);
    typedef struct packed {
        dma_state_e st;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        step  = 1'b0;
        done  = 1'b0;
        case (r_q.st)
            ST_IDLE: if (arm && dreq) begin
                r_d.st = ST_REQ;
                start  = 1'b1;
            end
            ST_REQ:    if (hlda) r_d.st = ST_ACK;
            ST_ACK:    r_d.st = ST_SETUP;
            ST_SETUP:  r_d.st = ST_STROBE;
            ST_STROBE: r_d.st = ST_RELEASE;
            ST_RELEASE: begin
                step = 1'b1;
                if (last) begin
                    r_d.st = ST_IDLE;
                    done   = 1'b1;
                end else begin
                    r_d.st = ST_SETUP;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.st <= ST_IDLE;
        else        r_q    <= r_d;
    end

    assign busy   = (r_q.st != ST_IDLE);
    assign hrq    = busy;
    assign dack   = (r_q.st == ST_ACK) || (r_q.st == ST_SETUP) ||
                    (r_q.st == ST_STROBE) || (r_q.st == ST_RELEASE);
    assign drive  = (r_q.st == ST_SETUP) || (r_q.st == ST_STROBE) ||
                    (r_q.st == ST_RELEASE);
    assign strobe = (r_q.st == ST_STROBE);

    p_grant_before_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACK) |-> $past(hlda));

    p_strobe_after_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(r_q.st == ST_SETUP));
endmodule

// File: rtl/dma_hold_engine.sv
module dma_hold_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 3,
    parameter int REG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              irq,
    input  logic              dev_req,
    output logic              dev_ack,
    output logic [DEV_W-1:0]  dev_sel,
    output logic              hold_req,
    input  logic              bus_grant,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr
);
    logic              arm, dir, busy, done, start, step, last, drive, strobe;
    logic [DEV_W-1:0]  dev;
    logic [ADDR_W-1:0] start_addr, cur_addr;
    logic [CNT_W-1:0]  count;

    dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .arm(arm), .dir(dir),
        .dev(dev), .start_addr(start_addr), .count(count), .irq(irq)
    );

    dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step), .busy(busy),
        .load_addr(start_addr), .load_cnt(count), .cur_addr(cur_addr), .last(last)
    );

    dma_seq u_seq (
        .clk(clk), .rst_n(rst_n), .arm(arm), .dreq(dev_req), .hlda(bus_grant),
        .last(last), .start(start), .step(step), .done(done), .busy(busy),
        .hrq(hold_req), .dack(dev_ack), .drive(drive), .strobe(strobe)
    );

    assign bus_addr = drive ? cur_addr : '0;
    assign dev_sel  = dev_ack ? dev : '0;
    assign mem_rd   = strobe && !dir;
    assign io_wr    = strobe && !dir;
    assign io_rd    = strobe && dir;
    assign mem_wr   = strobe && dir;

    p_hold_until_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_req) |-> (irq && !dev_ack));

    p_addr_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || io_rd || io_wr) |-> ($stable(bus_addr) && dev_ack));

    p_pairing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}) && (mem_rd == io_wr) && (mem_wr == io_rd));

    p_ack_needs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> hold_req);
endmodule

// File: tb/tb_dma_hold_engine.sv
`timescale 1ns/1ps
module tb_dma_hold_engine;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 3;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [RW-1:0] cfg_wdata = '0;
    logic          irq, dev_ack, hold_req, mem_rd, mem_wr, io_rd, io_wr;
    logic          dev_req = 1'b0;
    logic          bus_grant = 1'b0;
    logic [DW-1:0] dev_sel;
    logic [AW-1:0] bus_addr;

    int vectors = 0;
    int bad = 0;
    int grant_delay = 2;
    int grant_cnt = 0;

    always #2.5 clk = ~clk;

    dma_hold_engine #(.ADDR_W(AW), .CNT_W(CW), .DEV_W(DW), .REG_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .irq(irq), .dev_req(dev_req), .dev_ack(dev_ack),
        .dev_sel(dev_sel), .hold_req(hold_req), .bus_grant(bus_grant),
        .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
        .io_wr(io_wr)
    );

    // Processor stub: grants the bus a programmable number of clocks after hold_req
    always @(negedge clk) begin
        if (!hold_req) begin
            bus_grant <= 1'b0;
            grant_cnt <= 0;
        end else if (grant_cnt >= grant_delay) begin
            bus_grant <= 1'b1;
        end else begin
            grant_cnt <= grant_cnt + 1;
        end
    end

    // Reference model: phase 0 idle, 1 waiting, 2 acknowledge, 3..5 byte clocks
    int          m_phase;
    bit          m_arm, m_dir, m_irq;
    int          m_dev, m_addr_reg, m_cnt_reg, m_ptr, m_remaining;

    always @(posedge clk) begin
        bit finish_now;
        finish_now = 0;
        if (!rst_n) begin
            m_phase = 0; m_arm = 0; m_dir = 0; m_irq = 0;
            m_dev = 0; m_addr_reg = 0; m_cnt_reg = 0; m_ptr = 0; m_remaining = 0;
        end else begin
            if (m_phase == 0) begin
                if (m_arm && dev_req) begin
                    m_ptr = m_addr_reg;
                    m_remaining = (m_cnt_reg == 0) ? 1 : m_cnt_reg;
                    m_phase = 1;
                    if (cfg_we && cfg_sel != 2'd3) begin
                        // register write still lands: channel was idle this edge
                    end
                    if (cfg_we) apply_write();
                end else begin
                    if (cfg_we) apply_write();
                end
            end else begin
                if (cfg_we && cfg_sel == 2'd3 && cfg_wdata[0]) m_irq = 0;
                case (m_phase)
                    1: if (bus_grant) m_phase = 2;
                    2: m_phase = 3;
                    3: m_phase = 4;
                    4: m_phase = 5;
                    default: begin
                        m_remaining = m_remaining - 1;
                        m_ptr = (m_ptr + 1) % (1 << AW);
                        if (m_remaining == 0) begin
                            m_phase = 0;
                            finish_now = 1;
                        end else m_phase = 3;
                    end
                endcase
            end
            if (finish_now) begin
                m_arm = 0;
                m_irq = 1;
            end
        end
    end

    task automatic apply_write();
        case (cfg_sel)
            2'd0: begin
                m_arm = cfg_wdata[0];
                m_dir = cfg_wdata[1];
                m_dev = int'(cfg_wdata[2 +: DW]);
            end
            2'd1: m_addr_reg = int'(cfg_wdata[AW-1:0]);
            2'd2: m_cnt_reg  = int'(cfg_wdata[CW-1:0]);
            default: if (cfg_wdata[0]) m_irq = 0;
        endcase
    endtask

    task automatic cmp(input int act, input int exp, input string tag, input string what);
        vectors++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
        end
    endtask

    // Every clock: compare all outputs with the model
    always @(negedge clk) begin
        if (rst_n) begin
            cmp(int'(hold_req), int'(m_phase != 0), "R3", "hold_req");
            cmp(int'(dev_ack), int'(m_phase >= 2), "R4", "dev_ack");
            cmp(int'(dev_sel), (m_phase >= 2) ? m_dev : 0, "R4", "dev_sel");
            cmp(int'(bus_addr), (m_phase >= 3) ? m_ptr : 0, "R7", "bus_addr");
            cmp(int'(mem_rd), int'(m_phase == 4 && !m_dir), "R6", "mem_rd");
            cmp(int'(io_wr), int'(m_phase == 4 && !m_dir), "R6", "io_wr");
            cmp(int'(io_rd), int'(m_phase == 4 && m_dir), "R5", "io_rd");
            cmp(int'(mem_wr), int'(m_phase == 4 && m_dir), "R5", "mem_wr");
            cmp(int'(irq), int'(m_irq), "R9", "irq");
        end
    end

    task automatic wr(input logic [1:0] sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = RW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic run_xfer(input int delay);
        grant_delay = delay;
        @(negedge clk);
        dev_req = 1'b1;
        wait_irq();
        @(negedge clk);
        dev_req = 1'b0;
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog expired at %0t: actual hung expected finished", $time);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        cmp(int'(hold_req | dev_ack | mem_rd | mem_wr | io_rd | io_wr | irq), 0, "R1", "reset outputs");
        cmp(int'(bus_addr), 0, "R1", "reset address");
        rst_n = 1'b1;
        // R2: request while disarmed has no effect
        dev_req = 1'b1;
        repeat (6) @(negedge clk);
        cmp(int'(hold_req), 0, "R2", "disarmed request");
        dev_req = 1'b0;
        // R11 register layout: address at 1, count at 2, control at 0 (dev 5, memory to device)
        wr(2'd1, 16'h1000);
        wr(2'd2, 4);
        wr(2'd0, (5 << 2) | 1);
        run_xfer(3);   // R3 R4 R5 R6 R7
        cmp(int'(irq), 1, "R9", "irq after block");
        // R9: writing 0 to the clear bit leaves irq set
        wr(2'd3, 0);
        cmp(int'(irq), 1, "R9", "irq kept on zero write");
        wr(2'd3, 1);
        cmp(int'(irq), 0, "R9", "irq cleared");
        // R9: arm self-cleared, so a new request is ignored
        dev_req = 1'b1;
        repeat (4) @(negedge clk);
        cmp(int'(hold_req), 0, "R9", "disarmed after completion");
        dev_req = 1'b0;
        // R10: rewrite registers mid-transfer, then re-arm only
        wr(2'd0, (2 << 2) | 2 | 1);   // device to memory, dev 2
        grant_delay = 1;
        @(negedge clk);
        dev_req = 1'b1;
        repeat (8) @(negedge clk);
        wr(2'd1, 16'h2222);
        wr(2'd2, 9);
        wr(2'd0, 0);
        wait_irq();
        @(negedge clk);
        dev_req = 1'b0;
        wr(2'd3, 1);
        wr(2'd0, (2 << 2) | 2 | 1);
        run_xfer(0);   // R10 R7: must replay 0x1000, four bytes
        wr(2'd3, 1);
        // R8: count zero moves one byte
        wr(2'd1, 16'h00F0);
        wr(2'd2, 0);
        wr(2'd0, (7 << 2) | 1);
        run_xfer(2);
        cmp(int'(irq), 1, "R8", "zero count completes");
        wr(2'd3, 1);
        // single byte at the top of the address space
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 1);
        wr(2'd0, (1 << 2) | 1);
        run_xfer(4);
        wr(2'd3, 1);
        repeat (4) @(negedge clk);
        cmp(int'(irq), 0, "R9", "final clear");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end
endmodule